// File: doc/BRIEF.md
# Switch-Selected Waveform State Machine

This block is a four-state Moore machine. Three slide switches choose what it does, and it drives one active-low indicator line, `wave_n`. The two-bit state code goes straight out on `state_led` as active-high bits. The switches are asynchronous, so each one passes through a two-flop synchroniser before the next-state logic sees it.

The three modes are as follows:

- **Free-run.** With no mode switch set, the machine steps around its four states. `wave_n` is pulled low only in state 11, so the line carries a rectangular wave. With `duty_sw` low every state lasts one clock, which gives 75% high time. With `duty_sw` high the three high states and the low state dwell for parameterised numbers of clocks; the defaults give 30% high time.
- **Square-wave.** With `sq_sw` set, the machine parks in state 01. It toggles an internal wave bit every `HALF_TICKS` clocks, which is 41.6 ms at the default clock and gives a 12 Hz square wave. The half-period counter reloads and the wave bit clears on every entry, so the first half-period is always full length.
- **Hold.** With `hold_sw` set, the machine parks in state 11 and `wave_n` stays low, so the indicator stays lit.

A build-time parameter decides which mode wins when both mode switches are set.

Top module: `wavesel_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the block leaves that edge with `state_led` = 00 and `wave_n` = 1.
- R2: In free-run with `duty_sw` low, `state_led` advances by one each clock, in the order 00, 01, 10, 11, 00 (wrapping modulo 4).
- R3: In free-run, `wave_n` is 0 only in state 11, so with `duty_sw` low exactly one clock in every four is low (75% high).
- R4: In free-run with `duty_sw` high, states 00, 01 and 10 each last `HI_STEPS` clocks and state 11 lasts `LO_STEPS` clocks. With the defaults 1 and 7, exactly 7 of every 10 clocks are low (30% high).
- R5: With `sq_sw` effective, `state_led` is held at 01 and `wave_n` toggles every `HALF_TICKS` clocks. After entry, `wave_n` is 1 for a full `HALF_TICKS` clocks before the first toggle.
- R6: With `hold_sw` effective, `state_led` is 11 and `wave_n` is 0 for as long as the switch stays set.
- R7: When both mode switches are set, hold wins if `SW1_FIRST` = 0 and square-wave wins if `SW1_FIRST` = 1.
- R8: A switch change applied between edges reaches `state_led` and `wave_n` on the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sq_sw | input | 1 | Square-wave mode switch (asynchronous) |
| hold_sw | input | 1 | Hold-low mode switch (asynchronous) |
| duty_sw | input | 1 | Free-run duty select: 1 = 30%, 0 = 75% (asynchronous) |
| state_led | output | 2 | Current state code, active high |
| wave_n | output | 1 | Active-low indicator drive |

## Verification
Any switch change made at a falling edge shows up in `state_led` and `wave_n` at the third rising edge after it. That is two synchroniser stages plus the state register. Square-wave toggles then follow every `HALF_TICKS` edges, and free-run dwells last one or the programmed number of edges. The bench drives inputs at falling edges and advances its own expected machine at every rising edge. This model includes its own two-stage switch pipeline, so expected and actual values are compared at the following falling edge with the same latency the design has. The directed latency check samples after the second edge, where the old mode must still show, and again after the third edge.

// File: rtl/wavesel_fsm.sv
`timescale 1ns/1ps
module wavesel_fsm #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int HALF_TICKS = CLK_HZ / 10000 * 416,
  parameter int HI_STEPS   = 1,
  parameter int LO_STEPS   = 7,
  parameter int SW1_FIRST  = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sq_sw,
  input  logic       hold_sw,
  input  logic       duty_sw,
  output logic [1:0] state_led,
  output logic       wave_n
);
  localparam int TW    = $clog2(HALF_TICKS + 1);
  localparam int DMAX  = (HI_STEPS > LO_STEPS) ? HI_STEPS : LO_STEPS;
  localparam int DWW   = $clog2(DMAX + 1);
  localparam bit PRI_SQ = (SW1_FIRST != 0);
  localparam logic [TW-1:0]  RELOAD = TW'(HALF_TICKS - 1);
  localparam logic [DWW-1:0] HI_LD  = DWW'(HI_STEPS - 1);
  localparam logic [DWW-1:0] LO_LD  = DWW'(LO_STEPS - 1);

  logic [1:0]     sq_s, hold_s, duty_s;
  logic [1:0]     state;
  logic           wave;
  logic [TW-1:0]  tmr;
  logic [DWW-1:0] dwell;
  logic           sq_on, hold_on;
  logic [1:0]     next_st;
  logic [DWW-1:0] next_dw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_s   <= 2'b00;
      hold_s <= 2'b00;
      duty_s <= 2'b00;
    end else begin
      sq_s   <= {sq_s[0], sq_sw};
      hold_s <= {hold_s[0], hold_sw};
      duty_s <= {duty_s[0], duty_sw};
    end
  end

  assign sq_on   = sq_s[1] & (PRI_SQ | ~hold_s[1]);
  assign hold_on = hold_s[1] & ~(PRI_SQ & sq_s[1]);
  assign next_st = state + 2'd1;
  assign next_dw = !duty_s[1] ? '0 : (next_st == 2'd3) ? LO_LD : HI_LD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= 2'd0;
      wave  <= 1'b0;
      tmr   <= '0;
      dwell <= '0;
    end else if (hold_on) begin
      state <= 2'd3;
      wave  <= 1'b0;
      tmr   <= RELOAD;
      dwell <= '0;
    end else if (sq_on) begin
      dwell <= '0;
      if (state != 2'd1) begin
        state <= 2'd1;
        wave  <= 1'b0;
        tmr   <= RELOAD;
      end else if (tmr == '0) begin
        wave <= ~wave;
        tmr  <= RELOAD;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end else begin
      wave <= 1'b0;
      tmr  <= RELOAD;
      if (dwell == '0) begin
        state <= next_st;
        dwell <= next_dw;
      end else begin
        dwell <= dwell - 1'b1;
      end
    end
  end

  assign state_led = state;
  assign wave_n    = (state == 2'd3) ? 1'b0 : (state == 2'd1) ? ~wave : 1'b1;
endmodule

// File: rtl/wavesel_fsm_chk.sv
`timescale 1ns/1ps
module wavesel_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       sq_on,
  input logic       hold_on,
  input logic       tmr_zero,
  input logic       dwell_zero,
  input logic [1:0] state_led,
  input logic       wave_n
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    primed && $past(rst) |-> (state_led == 2'd0 && wave_n));

  // R3
  high_states_chk: assert property (@(posedge clk) disable iff (rst)
    (state_led == 2'd0 || state_led == 2'd2) |-> wave_n);

  // R2
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!sq_on && !hold_on && dwell_zero) |=> (state_led == $past(state_led) + 2'd1));

  // R5
  square_park_chk: assert property (@(posedge clk) disable iff (rst)
    sq_on |=> (state_led == 2'd1));

  // R5
  square_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_on && state_led == 2'd1 && !tmr_zero) |=> $stable(wave_n));

  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    hold_on |=> (state_led == 2'd3 && !wave_n));
endmodule

bind wavesel_fsm wavesel_fsm_chk u_chk (
  .clk(clk), .rst(rst), .sq_on(sq_on), .hold_on(hold_on),
  .tmr_zero(tmr == '0), .dwell_zero(dwell == '0),
  .state_led(state_led), .wave_n(wave_n)
);

// File: tb/sim_wavesel_fsm.sv
`timescale 1ns/1ps
module sim_wavesel_fsm;
  localparam int HT = 5;
  localparam int HI = 1;
  localparam int LO = 7;

  logic clk = 1'b0, rst = 1'b1, sq = 1'b0, hd = 1'b0, dt = 1'b0;
  logic [1:0] st_o [2];
  logic       w_o  [2];
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  wavesel_fsm #(.HALF_TICKS(HT), .HI_STEPS(HI), .LO_STEPS(LO), .SW1_FIRST(0)) u0 (
    .clk(clk), .rst(rst), .sq_sw(sq), .hold_sw(hd), .duty_sw(dt),
    .state_led(st_o[0]), .wave_n(w_o[0]));

  wavesel_fsm #(.HALF_TICKS(HT), .HI_STEPS(HI), .LO_STEPS(LO), .SW1_FIRST(1)) u1 (
    .clk(clk), .rst(rst), .sq_sw(sq), .hold_sw(hd), .duty_sw(dt),
    .state_led(st_o[1]), .wave_n(w_o[1]));

  // expected machines, one per priority option
  int mst [2], mdw [2], mtm [2];
  bit mwv [2];
  bit qs1, qh1, qd1, qs2, qh2, qd2;

  function automatic bit sq_eff(int m);
    return qs2 && ((m == 1) || !qh2);
  endfunction

  function automatic bit hd_eff(int m);
    return qh2 && !((m == 1) && qs2);
  endfunction

  function automatic bit exp_w(int m);
    if (mst[m] == 3) return 1'b0;
    if (mst[m] == 1) return !mwv[m];
    return 1'b1;
  endfunction

  function automatic string tag_of(int m);
    if (hd_eff(m)) return "R6";
    if (sq_eff(m)) return "R5";
    if (qd2) return "R4";
    return "R2";
  endfunction

  task automatic model_step(input int m);
    if (hd_eff(m)) begin
      mst[m] = 3; mwv[m] = 1'b0; mtm[m] = HT - 1; mdw[m] = 0;
    end else if (sq_eff(m)) begin
      mdw[m] = 0;
      if (mst[m] != 1) begin
        mst[m] = 1; mwv[m] = 1'b0; mtm[m] = HT - 1;
      end else if (mtm[m] == 0) begin
        mwv[m] = !mwv[m]; mtm[m] = HT - 1;
      end else begin
        mtm[m] = mtm[m] - 1;
      end
    end else begin
      mwv[m] = 1'b0; mtm[m] = HT - 1;
      if (mdw[m] == 0) begin
        mst[m] = (mst[m] + 1) % 4;
        mdw[m] = !qd2 ? 0 : (mst[m] == 3) ? LO - 1 : HI - 1;
      end else begin
        mdw[m] = mdw[m] - 1;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < 2; m++) begin
        mst[m] = 0; mdw[m] = 0; mtm[m] = 0; mwv[m] = 1'b0;
      end
      qs1 = 0; qh1 = 0; qd1 = 0; qs2 = 0; qh2 = 0; qd2 = 0;
    end else begin
      for (int m = 0; m < 2; m++) model_step(m);
      qs2 = qs1; qh2 = qh1; qd2 = qd1;
      qs1 = sq;  qh1 = hd;  qd1 = dt;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the expected machines (R8 latency included)
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int m = 0; m < 2; m++) begin
        check({st_o[m], w_o[m]} == {2'(mst[m]), exp_w(m)}, tag_of(m),
              {st_o[m], w_o[m]}, {2'(mst[m]), exp_w(m)});
      end
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    int highs;
    bit ok;
    logic [1:0] prev;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R1
    check(st_o[0] == 2'd0 && w_o[0] == 1'b1, "R1", {st_o[0], w_o[0]}, 1);
    check(st_o[1] == 2'd0 && w_o[1] == 1'b1, "R1", {st_o[1], w_o[1]}, 1);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R2 / R3: free-run at 75%
    repeat (10) @(negedge clk);
    ok = 1'b1;
    prev = st_o[0];
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (st_o[0] != prev + 2'd1) ok = 1'b0;
      prev = st_o[0];
    end
    check(ok, "R2", ok, 1);
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!w_o[0]) lows++;
    end
    check(lows == 2, "R3", lows, 2);

    // R4: free-run at 30%
    dt = 1'b1;
    repeat (20) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!w_o[0]) lows++;
    end
    check(lows == 14, "R4", lows, 14);

    // R5: square wave, steady state
    dt = 1'b0;
    sq = 1'b1;
    repeat (10) @(negedge clk);
    lows = 0;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!w_o[0]) lows++;
      if (st_o[0] != 2'd1) ok = 1'b0;
    end
    check(lows == 20, "R5", lows, 20);
    check(ok, "R5", ok, 1);

    // R8: latency from square to hold
    sq = 1'b0;
    hd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(st_o[0] == 2'd1, "R8", st_o[0], 1);
    @(negedge clk);
    check(st_o[0] == 2'd3 && w_o[0] == 1'b0, "R6", {st_o[0], w_o[0]}, 6);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (st_o[0] != 2'd3 || w_o[0]) ok = 1'b0;
    end
    check(ok, "R6", ok, 1);

    // R5: first half-period after entry is full length
    hd = 1'b0;
    sq = 1'b1;
    repeat (3) @(negedge clk);
    check(st_o[0] == 2'd1 && w_o[0] == 1'b1, "R5", {st_o[0], w_o[0]}, 3);
    highs = 0;
    while (w_o[0] && highs < 50) begin
      highs++;
      @(negedge clk);
    end
    check(highs == HT, "R5", highs, HT);

    // R7: both mode switches set
    hd = 1'b1;
    repeat (6) @(negedge clk);
    check(st_o[0] == 2'd3 && w_o[0] == 1'b0, "R7", {st_o[0], w_o[0]}, 6);
    check(st_o[1] == 2'd1, "R7", st_o[1], 1);

    // constrained random switch patterns
    for (int i = 0; i < 2500; i++) begin
      int len;
      int pick;
      pick = int'($urandom % 8);
      sq = (pick == 0 || pick == 5);
      hd = (pick == 1 || pick == 5);
      dt = $urandom % 2;
      len = 1 + int'($urandom % 25);
      repeat (len) @(negedge clk);
    end

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule